// File: doc/BRIEF.md
# Prioritised Interrupt Request Controller

This block keeps three state bits per interrupt line (enabled, pending, in service) for up to 82 lines. It chooses one line to offer to a processor. Software reaches the state through a 32-bit register port with word addressing. Enable state and pending state each have two banks: one sets bits and the other clears them, and writing a 0 to either bank changes nothing. A third bank shows the in-service state and cannot be written. Each line also has an 8-bit priority byte that holds only a 4-bit urgency value.

Among the lines that are both pending and enabled, the one with the lowest urgency value wins, and the lowest line number breaks ties. A grouping input divides the urgency value into a preemption part in its upper bits and a sub-priority part below it. The winner is offered to the processor only when no line is in service, or when its preemption part is strictly lower than the lowest preemption part among the lines in service. An acknowledge moves the offered line from pending to in service. An end-of-service strobe names a line and clears its in-service bit. A level on a hardware input line also sets that line's pending bit.

Top module: `irq_ctrl_core`

## Requirements
- R1: After reset, every enable, pending, in-service and priority bit is 0, and `req_valid` is 0.
- R2: A write of 1 to a bit of the enable-set bank (word address 0x00+w) enables that line, and a write of 1 to the enable-clear bank (0x08+w) disables it. Bits written as 0 leave the state unchanged. Both banks read back the enable state.
- R3: A write of 1 to the pending-set bank (0x10+w) makes a line pending, and a write of 1 to the pending-clear bank (0x18+w) removes it. While `irq_in[n]` is high, line n is made pending. Both banks read back the pending state.
- R4: Line n sits in word w = n/32 at bit n%32. Bits for lines at 82 and above read as 0 and ignore writes.
- R5: Priority word 0x40+k holds the bytes of lines 4k..4k+3, with line 4k+j in bits [8j+7:8j]. Only bits [8j+7:8j+4] are stored. The low nibble of each byte reads 0, and bytes of lines that do not exist read 0.
- R6: With nothing in service, `req_valid` is 1 exactly when some line is both pending and enabled, and `req_id` is the line with the lowest urgency value. On equal values the lower line number wins.
- R7: When `cpu_ack` is high while `req_valid` is high, the line `req_id` is no longer pending and is in service from the next cycle on.
- R8: The in-service bank (0x20+w) cannot be written. A write to it leaves the in-service state unchanged.
- R9: When `cpu_eoi` is high, the in-service bit of line `eoi_id` is 0 from the next cycle on.
- R10: While any line is in service, the winner is offered only if its preemption field is strictly lower than the lowest preemption field among the lines in service.
- R11: `prio_group` value g selects min(g,4) preemption bits, taken from the top of the urgency value. With 0 bits, nothing preempts a line in service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | 82 | Hardware request levels, one per line |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| prio_group | input | 3 | Split between preemption and sub-priority |
| req_valid | output | 1 | A line is offered to the processor |
| req_id | output | 7 | Number of the offered line |
| cpu_ack | input | 1 | Accept the offered line |
| cpu_eoi | input | 1 | End of service for `eoi_id` |
| eoi_id | input | 7 | Line whose service ends |

## Verification
The bench sets and clears enable and pending for every line one at a time. This separates errors in word selection and bit position from errors in set/clear polarity. Arbitration is tested on several pending masks over a priority pattern that repeats every 16 lines. Because of that repetition, equal values occur and the tie-break rule is exercised as well as the ordering by urgency. The preemption gate is swept over every pair of in-service and requesting urgency values, for each of the eight grouping codes. This shows whether the strict-less comparison, the width of the preemption field and the clamping of codes above 4 are correct.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int PRIO_W = 4;

    typedef enum logic [3:0] {
        BANK_EN_SET   = 4'd0,
        BANK_EN_CLR   = 4'd1,
        BANK_PEND_SET = 4'd2,
        BANK_PEND_CLR = 4'd3,
        BANK_ACTIVE   = 4'd4
    } bank_e;

    // Mask selecting the preemption bits of an urgency value; grouping codes
    // above PRIO_W are clamped to PRIO_W.
    function automatic logic [PRIO_W-1:0] preempt_mask(input logic [2:0] grp);
        int nbits;
        logic [PRIO_W-1:0] m;
        nbits = (int'(grp) > PRIO_W) ? PRIO_W : int'(grp);
        m = '0;
        for (int i = 0; i < PRIO_W; i++) begin
            if (i >= PRIO_W - nbits) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/irq_prio_arbiter.sv
module irq_prio_arbiter #(
    parameter int N_LINES = 82,
    parameter int PW      = 4,
    parameter int IDW     = 7
) (
    input  logic [N_LINES-1:0]         cand,
    input  logic [N_LINES-1:0][PW-1:0] prio,
    output logic                       win_valid,
    output logic [IDW-1:0]             win_id,
    output logic [PW-1:0]              win_prio
);

    // Ascending scan: a later line replaces the holder only on a strictly
    // lower value, so ties stay with the lower line number.
    always_comb begin
        win_valid = 1'b0;
        win_id    = '0;
        win_prio  = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (cand[i] && (!win_valid || (prio[i] < win_prio))) begin
                win_valid = 1'b1;
                win_id    = IDW'(i);
                win_prio  = prio[i];
            end
        end
    end

endmodule

// File: rtl/irq_preempt_gate.sv
module irq_preempt_gate #(
    parameter int N_LINES = 82,
    parameter int PW      = 4
) (
    input  logic [N_LINES-1:0]         act,
    input  logic [N_LINES-1:0][PW-1:0] prio,
    input  logic [2:0]                 grp,
    input  logic                       win_valid,
    input  logic [PW-1:0]              win_prio,
    output logic                       offer
);

    logic [PW-1:0] mask;
    logic [PW-1:0] run_level;
    logic          any_act;

    always_comb begin
        mask      = irq_pkg::preempt_mask(grp);
        any_act   = |act;
        run_level = '1;
        for (int i = 0; i < N_LINES; i++) begin
            if (act[i] && ((prio[i] & mask) < run_level)) run_level = prio[i] & mask;
        end
        offer = win_valid && (!any_act || ((win_prio & mask) < run_level));
    end

endmodule

// File: rtl/irq_ctrl_core.sv
module irq_ctrl_core #(
    parameter int N_LINES = 82,
    parameter int ADDR_W  = 7,
    parameter int DATA_W  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] irq_in,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    input  logic [2:0]         prio_group,
    output logic               req_valid,
    output logic [$clog2(N_LINES)-1:0] req_id,
    input  logic               cpu_ack,
    input  logic               cpu_eoi,
    input  logic [$clog2(N_LINES)-1:0] eoi_id
);
    import irq_pkg::*;

    localparam int PW      = irq_pkg::PRIO_W;
    localparam int IDW     = $clog2(N_LINES);
    localparam int N_WORDS = (N_LINES + DATA_W - 1) / DATA_W;
    localparam int PAD_W   = N_WORDS * DATA_W;
    localparam int BPW     = DATA_W / 8;
    localparam int N_PWORD = (N_LINES + BPW - 1) / BPW;

    typedef struct packed {
        logic [N_LINES-1:0]         en;
        logic [N_LINES-1:0]         pend;
        logic [N_LINES-1:0]         act;
        logic [N_LINES-1:0][PW-1:0] prio;
    } state_t;

    state_t s_d, s_q;

    logic          is_prio;
    bank_e         bank;
    logic [2:0]    widx;
    logic [5:0]    pidx;
    logic          win_valid;
    logic [IDW-1:0] win_id;
    logic [PW-1:0] win_prio;

    assign is_prio = bus_addr[6];
    assign bank    = bank_e'({1'b0, bus_addr[5:3]});
    assign widx    = bus_addr[2:0];
    assign pidx    = bus_addr[5:0];

    irq_prio_arbiter #(.N_LINES(N_LINES), .PW(PW), .IDW(IDW)) u_arb (
        .cand      (s_q.pend & s_q.en),
        .prio      (s_q.prio),
        .win_valid (win_valid),
        .win_id    (win_id),
        .win_prio  (win_prio)
    );

    irq_preempt_gate #(.N_LINES(N_LINES), .PW(PW)) u_gate (
        .act       (s_q.act),
        .prio      (s_q.prio),
        .grp       (prio_group),
        .win_valid (win_valid),
        .win_prio  (win_prio),
        .offer     (req_valid)
    );

    assign req_id = win_id;

    // Next-state computation
    always_comb begin
        logic [PAD_W-1:0]   wpad;
        logic [N_LINES-1:0] wl;
        logic [N_LINES-1:0] set_p, clr_p, ack_m, eoi_m;
        s_d  = s_q;
        wpad = '0;
        if (bus_we && !is_prio && (int'(widx) < N_WORDS))
            wpad[int'(widx)*DATA_W +: DATA_W] = bus_wdata;
        wl = wpad[N_LINES-1:0];

        if (bank == BANK_EN_SET) s_d.en = s_q.en | wl;
        if (bank == BANK_EN_CLR) s_d.en = s_q.en & ~wl;

        set_p = irq_in | ((bank == BANK_PEND_SET) ? wl : '0);
        clr_p = (bank == BANK_PEND_CLR) ? wl : '0;
        ack_m = '0;
        if (cpu_ack && req_valid) ack_m[win_id] = 1'b1;
        eoi_m = '0;
        if (cpu_eoi && (int'(eoi_id) < N_LINES)) eoi_m[eoi_id] = 1'b1;

        s_d.pend = ((s_q.pend | set_p) & ~clr_p) & ~ack_m;
        s_d.act  = (s_q.act | ack_m) & ~eoi_m;

        if (bus_we && is_prio) begin
            for (int j = 0; j < BPW; j++) begin
                if (int'(pidx) * BPW + j < N_LINES)
                    s_d.prio[int'(pidx) * BPW + j] = bus_wdata[8*j+8-PW +: PW];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Register read port
    always_comb begin
        logic [PAD_W-1:0] en_p, pend_p, act_p;
        en_p      = PAD_W'(s_q.en);
        pend_p    = PAD_W'(s_q.pend);
        act_p     = PAD_W'(s_q.act);
        bus_rdata = '0;
        if (is_prio) begin
            for (int j = 0; j < BPW; j++) begin
                if ((int'(pidx) < N_PWORD) && (int'(pidx) * BPW + j < N_LINES))
                    bus_rdata[8*j+8-PW +: PW] = s_q.prio[int'(pidx) * BPW + j];
            end
        end else if (int'(widx) < N_WORDS) begin
            case (bank)
                BANK_EN_SET, BANK_EN_CLR:     bus_rdata = en_p[int'(widx)*DATA_W +: DATA_W];
                BANK_PEND_SET, BANK_PEND_CLR: bus_rdata = pend_p[int'(widx)*DATA_W +: DATA_W];
                BANK_ACTIVE:                  bus_rdata = act_p[int'(widx)*DATA_W +: DATA_W];
                default:                      bus_rdata = '0;
            endcase
        end
    end

    // Assertions
    assert_offer_is_candidate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (s_q.en[req_id] && s_q.pend[req_id]));

    assert_ack_enters_service_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ack && req_valid && !(cpu_eoi && eoi_id == req_id)) |=> s_q.act[$past(req_id)]);

    assert_eoi_leaves_service_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_eoi && int'(eoi_id) < N_LINES) |=> !s_q.act[$past(eoi_id)]);

    assert_active_not_writable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !is_prio && bank == BANK_ACTIVE && !cpu_ack && !cpu_eoi) |=> $stable(s_q.act));

    assert_preempt_needs_lower_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (|s_q.act) && prio_group == 3'd0) |-> 1'b0);

endmodule

// File: tb/irq_ctrl_core_test.sv
module irq_ctrl_core_test;
    localparam int  N      = 82;
    localparam time CLK_PER = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] irq_in = '0;
    logic        bus_we = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  prio_group = '0;
    logic        req_valid;
    logic [6:0]  req_id;
    logic        cpu_ack = 1'b0;
    logic        cpu_eoi = 1'b0;
    logic [6:0]  eoi_id = '0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PER/2) clk = ~clk;

    irq_ctrl_core uut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .prio_group(prio_group), .req_valid(req_valid), .req_id(req_id),
        .cpu_ack(cpu_ack), .cpu_eoi(cpu_eoi), .eoi_id(eoi_id)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic ack();
        @(negedge clk); cpu_ack = 1'b1;
        @(negedge clk); cpu_ack = 1'b0;
    endtask

    task automatic eoi(input int id);
        @(negedge clk); cpu_eoi = 1'b1; eoi_id = 7'(id);
        @(negedge clk); cpu_eoi = 1'b0;
    endtask

    function automatic logic [3:0] pat(input int n);
        return 4'((n * 7 + 3) % 16);
    endfunction

    function automatic logic [31:0] onebit(input int n);
        return 32'(1) << (n % 32);
    endfunction

    task automatic clear_all_pending();
        for (int w = 0; w < 3; w++) wr(7'(8'h18 + w), 32'hFFFF_FFFF);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int w = 0; w < 3; w++) begin
            rd(7'(8'h00 + w), d); chk("R1 enable", d, 0);
            rd(7'(8'h10 + w), d); chk("R1 pending", d, 0);
            rd(7'(8'h20 + w), d); chk("R1 active", d, 0);
        end
        for (int k = 0; k < 21; k++) begin rd(7'(8'h40 + k), d); chk("R1 prio", d, 0); end
        chk("R1 req_valid", 32'(req_valid), 0);

        // R2 / R3 / R4: per-line set/clear mapping
        for (int n = 0; n < N; n++) begin
            wr(7'(8'h00 + n/32), onebit(n));
            rd(7'(8'h08 + n/32), d); chk("R2 R4 enable set", d, onebit(n));
            wr(7'(8'h00 + n/32), 32'h0);
            rd(7'(8'h00 + n/32), d); chk("R2 zero write keeps", d, onebit(n));
            wr(7'(8'h08 + n/32), onebit(n));
            rd(7'(8'h00 + n/32), d); chk("R2 enable clear", d, 0);
            wr(7'(8'h10 + n/32), onebit(n));
            rd(7'(8'h18 + n/32), d); chk("R3 R4 pending set", d, onebit(n));
            wr(7'(8'h18 + n/32), 32'h0);
            rd(7'(8'h10 + n/32), d); chk("R3 zero write keeps", d, onebit(n));
            wr(7'(8'h18 + n/32), onebit(n));
            rd(7'(8'h10 + n/32), d); chk("R3 pending clear", d, 0);
        end
        wr(7'h02, 32'hFFFF_FFFF);
        rd(7'h02, d); chk("R4 unimplemented bits", d, 32'h0003_FFFF);
        wr(7'h12, 32'hFFFF_FFFF);
        rd(7'h12, d); chk("R4 unimplemented pending bits", d, 32'h0003_FFFF);
        wr(7'h0A, 32'hFFFF_FFFF);
        clear_all_pending();

        // R3: hardware level sets pending
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); irq_in[40] = 1'b0;
        rd(7'h11, d); chk("R3 irq_in sets pending", d, 32'h0000_0100);
        clear_all_pending();

        // R5: priority bytes
        for (int k = 0; k < 21; k++) begin
            logic [31:0] wv;
            for (int j = 0; j < 4; j++) wv[8*j +: 8] = {pat(4*k+j), 4'hF};
            wr(7'(8'h40 + k), wv);
        end
        for (int k = 0; k < 21; k++) begin
            logic [31:0] ev;
            ev = '0;
            for (int j = 0; j < 4; j++)
                if (4*k+j < N) ev[8*j +: 8] = {pat(4*k+j), 4'h0};
            rd(7'(8'h40 + k), d); chk("R5 prio readback", d, ev);
        end

        // R6: arbitration over several pending masks (nothing in service)
        for (int w = 0; w < 3; w++) wr(7'(8'h00 + w), 32'hFFFF_FFFF);
        for (int p = 0; p < 10; p++) begin
            logic [N-1:0] pm;
            int best;
            pm = '0;
            for (int n = 0; n < N; n++)
                if (((n * 13 + p * 5) % (p + 2)) == 0 || (p == 9)) pm[n] = 1'b1;
            for (int w = 0; w < 3; w++) begin
                logic [95:0] pad;
                pad = 96'(pm);
                wr(7'(8'h10 + w), pad[32*w +: 32]);
            end
            best = -1;
            for (int n = 0; n < N; n++)
                if (pm[n] && (best < 0 || pat(n) < pat(best))) best = n;
            @(negedge clk);
            chk("R6 req_valid", 32'(req_valid), 32'(best >= 0));
            chk("R6 req_id", 32'(req_id), 32'(best));
            clear_all_pending();
        end
        @(negedge clk);
        chk("R6 no candidate", 32'(req_valid), 0);

        // R7 / R8 / R9: acknowledge, read-only active bank, end of service
        wr(7'h10, 32'h0000_0030);  // lines 4 (pat 15) and 5 (pat 6)
        @(negedge clk);
        chk("R6 pick line5", 32'(req_id), 5);
        ack();
        rd(7'h20, d); chk("R7 active after ack", d, 32'h0000_0020);
        rd(7'h10, d); chk("R7 pending after ack", d, 32'h0000_0010);
        wr(7'h20, 32'hFFFF_FFFF);
        rd(7'h20, d); chk("R8 active write ignored", d, 32'h0000_0020);
        wr(7'h21, 32'hFFFF_FFFF);
        rd(7'h21, d); chk("R8 active word1 unchanged", d, 0);
        eoi(5);
        rd(7'h20, d); chk("R9 active cleared", d, 0);
        @(negedge clk);
        chk("R9 next offered", 32'(req_id), 4);
        clear_all_pending();

        // R10 / R11: preemption sweep, line 8 in service, line 9 requesting
        for (int a = 0; a < 16; a++) begin
            wr(7'h42, {16'h0, 8'h00, 4'(a), 4'h0});
            wr(7'h10, 32'h0000_0100);
            ack();
            rd(7'h20, d); chk("R7 line8 in service", d, 32'h0000_0100);
            wr(7'h10, 32'h0000_0200);
            for (int b = 0; b < 16; b++) begin
                wr(7'h42, {16'h0, 4'(b), 4'h0, 4'(a), 4'h0});
                for (int g = 0; g < 8; g++) begin
                    int pb;
                    bit exp_v;
                    pb = (g > 4) ? 4 : g;
                    exp_v = (pb > 0) && ((b >> (4 - pb)) < (a >> (4 - pb)));
                    prio_group = 3'(g);
                    #1;
                    chk("R10 R11 preempt gate", 32'(req_valid), 32'(exp_v));
                end
            end
            prio_group = 3'd0;
            clear_all_pending();
            eoi(8);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule